// File: doc/BRIEF.md
# Timer Clock Prescaler and Selector

This block decides, for every system clock cycle, whether a timer/counter should advance. A 3-bit select code chooses the count source: stopped, every system cycle, one of four power-of-two divided taps taken from a free-running 10-bit prescaler, or single-cycle edge pulses that an external pin synchronizer delivers for rising and for falling edges. The result is a registered count-enable strobe that is high for one system cycle per count.

The prescaler counts on every system cycle whatever code is selected. Changing the select code therefore never moves its phase, and the delay to the first count after a divided tap is selected depends on where the prescaler happens to be. Software that needs a known alignment raises the synchronous prescaler-clear input. This zeroes the counter so that the next divided counts fall at fixed distances from that point.

Top module: `tclk_sel_top`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `cnt_en_o` is 0 and the prescaler is zero. The first count on a divided tap selected from release comes N cycles after the release edge.
- R2: Select code 0 stops counting: `cnt_en_o` is 0 one cycle after every edge at which code 0 is sampled, whatever the other inputs are.
- R3: Select code 1 gives the undivided clock: `cnt_en_o` is 1 one cycle after every edge at which code 1 is sampled.
- R4: Select codes 2, 3, 4 and 5 choose divisors N = 8, 64, 256 and 1024. `cnt_en_o` is high for exactly one cycle out of every N, in the cycle after the edge where the prescaler's low log2(N) bits return to zero. That cycle is N, 2N, 3N... edges after the last prescaler clear.
- R5: The prescaler keeps running under every select code and is not cleared when the code changes. After a divided tap is selected, the first count follows 1 to N cycles later (within the 1 to N+1 bound), set by the prescaler phase.
- R6: Code 6 counts falling-edge pulses on `ext_fall_i` and code 7 counts rising-edge pulses on `ext_rise_i`. `cnt_en_o` follows the chosen pulse one cycle later, and the pulse input that is not chosen has no effect.
- R7: `pre_clr_i` is synchronous. At the edge where it is sampled the prescaler becomes zero, and a divided tap gives no count in the following cycle. Codes 0, 1, 6 and 7 are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 3 | Count source code (0 stop, 1 direct, 2..5 taps /8 /64 /256 /1024, 6 falling, 7 rising) |
| pre_clr_i | input | 1 | Synchronous prescaler clear request |
| ext_rise_i | input | 1 | One-cycle pulse per synchronized rising edge of the external clock |
| ext_fall_i | input | 1 | One-cycle pulse per synchronized falling edge of the external clock |
| cnt_en_o | output | 1 | Count-enable strobe, one system cycle per count |

## Verification
Every result lands exactly one cycle after the edge that samples its inputs. This holds for the stop and direct codes, for external pulses, and for tap counts, where the sampled prescaler phase decides the outcome. The bench drives inputs between edges, works out the expected strobe from its own cycle count since the last reset or clear, and reads `cnt_en_o` 1 ns after the next edge. First-count latency is measured as the number of edges from the edge that first samples a new tap code to the first high strobe. This figure is checked against the phase predicted from the bench's own count.

// File: rtl/tclk_pkg.sv
package tclk_pkg;

    localparam int SEL_W    = 3;
    localparam int PRE_W    = 10;
    localparam int NUM_TAPS = 4;
    localparam int TAP_BASE = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_STOP     = 3'd0,
        SEL_DIRECT   = 3'd1,
        SEL_DIV8     = 3'd2,
        SEL_DIV64    = 3'd3,
        SEL_DIV256   = 3'd4,
        SEL_DIV1024  = 3'd5,
        SEL_EXT_FALL = 3'd6,
        SEL_EXT_RISE = 3'd7
    } sel_e;

    // log2 of the divisor of each tap, lowest divisor first
    function automatic int tap_log(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tclk_prescaler.sv
module tclk_prescaler #(
    parameter int CNT_W    = tclk_pkg::PRE_W,
    parameter int NUM_TAPS = tclk_pkg::NUM_TAPS
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                clr_i,
    output logic [NUM_TAPS-1:0] wrap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A tap fires when its low bits are about to roll over to zero
    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        localparam int LOGN = tclk_pkg::tap_log(t);
        assign wrap_o[t] = (&st_q.cnt[LOGN-1:0]) & ~clr_i;
    end

    p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (st_q.cnt == '0));

    p_free_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1)));

endmodule

// File: rtl/tclk_src_mux.sv
module tclk_src_mux #(
    parameter int SEL_W    = tclk_pkg::SEL_W,
    parameter int NUM_TAPS = tclk_pkg::NUM_TAPS
) (
    input  logic [SEL_W-1:0]    sel_i,
    input  logic [NUM_TAPS-1:0] tap_i,
    input  logic                rise_i,
    input  logic                fall_i,
    output logic                en_o
);
    import tclk_pkg::*;

    always_comb begin
        en_o = 1'b0;
        case (sel_i)
            SEL_STOP:     en_o = 1'b0;
            SEL_DIRECT:   en_o = 1'b1;
            SEL_EXT_FALL: en_o = fall_i;
            SEL_EXT_RISE: en_o = rise_i;
            default: begin
                for (int k = 0; k < NUM_TAPS; k++) begin
                    if (int'(sel_i) == k + TAP_BASE) begin
                        en_o = tap_i[k];
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/tclk_sel_top.sv
module tclk_sel_top (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [tclk_pkg::SEL_W-1:0] sel_i,
    input  logic                       pre_clr_i,
    input  logic                       ext_rise_i,
    input  logic                       ext_fall_i,
    output logic                       cnt_en_o
);
    import tclk_pkg::*;

    typedef struct packed {
        logic en;
    } out_state_t;

    out_state_t           st_d, st_q;
    logic [NUM_TAPS-1:0]  wrap;
    logic                 pick;

    tclk_prescaler #(
        .CNT_W    (PRE_W),
        .NUM_TAPS (NUM_TAPS)
    ) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (pre_clr_i),
        .wrap_o (wrap)
    );

    tclk_src_mux #(
        .SEL_W    (SEL_W),
        .NUM_TAPS (NUM_TAPS)
    ) u_mux (
        .sel_i  (sel_i),
        .tap_i  (wrap),
        .rise_i (ext_rise_i),
        .fall_i (ext_fall_i),
        .en_o   (pick)
    );

    always_comb begin
        st_d    = st_q;
        st_d.en = pick;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_en_o = st_q.en;

    p_stop_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == SEL_STOP) |=> !cnt_en_o);

    p_direct_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == SEL_DIRECT) |=> cnt_en_o);

    p_rise_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == SEL_EXT_RISE) |=> (cnt_en_o == $past(ext_rise_i)));

    p_fall_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == SEL_EXT_FALL) |=> (cnt_en_o == $past(ext_fall_i)));

    p_clr_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pre_clr_i && (sel_i >= SEL_DIV8) && (sel_i <= SEL_DIV1024)) |=> !cnt_en_o);

    p_tap_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_en_o && (sel_i >= SEL_DIV8) && (sel_i <= SEL_DIV1024)
         && ($past(sel_i) == sel_i)) |=> !cnt_en_o);

endmodule

// File: tb/tclk_sel_top_tb_top.sv
module tclk_sel_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       clr = 1'b0;
    logic       rise = 1'b0;
    logic       fall = 1'b0;
    logic       en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int model_cnt = 0;

    always #5 clk = ~clk;

    tclk_sel_top dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .sel_i      (sel),
        .pre_clr_i  (clr),
        .ext_rise_i (rise),
        .ext_fall_i (fall),
        .cnt_en_o   (en)
    );

    function automatic int divisor(input logic [2:0] s);
        case (s)
            3'd2:    return 8;
            3'd3:    return 64;
            3'd4:    return 256;
            default: return 1024;
        endcase
    endfunction

    function automatic bit is_tap(input logic [2:0] s);
        return (s >= 3'd2) && (s <= 3'd5);
    endfunction

    // expected strobe after the next edge; cnt is the cycle count since last clear
    function automatic bit expect_en(input logic [2:0] s, input int cnt,
                                     input bit c, input bit r, input bit f);
        if (s == 3'd0) return 1'b0;
        if (s == 3'd1) return 1'b1;
        if (s == 3'd6) return f;
        if (s == 3'd7) return r;
        if (c) return 1'b0;
        return ((cnt + 1) % divisor(s)) == 0;
    endfunction

    function automatic string tag_of(input logic [2:0] s, input bit c);
        if (s == 3'd0) return "R2";
        if (s == 3'd1) return "R3";
        if (s >= 3'd6) return "R6";
        if (c) return "R7";
        return "R4";
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // one edge: predict, advance the bench counter, sample 1 ns after the edge
    task automatic step();
        bit    e;
        string tg;
        e  = expect_en(sel, model_cnt, clr, rise, fall);
        tg = tag_of(sel, clr);
        model_cnt = clr ? 0 : (model_cnt + 1) % 1024;
        @(posedge clk);
        #1;
        check(en === e, tg, int'(en), int'(e));
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        int seed;
        int lat;
        int exp_lat;
        int ph;
        int cnt_hi;
        seed = 32'h5EED_0013;
        void'($urandom(seed));

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(en === 1'b0, "R1", int'(en), 0);
        @(negedge clk);
        sel = 3'd2;
        rst_n = 1'b1;
        model_cnt = 0;
        // first count N edges after release: count edges to first strobe
        lat = 0;
        for (int i = 0; i < 20 && lat == 0; i++) begin
            step();
            if (en) lat = i + 1;
        end
        check(lat == 8, "R1", lat, 8);

        // R2: stopped, random ext pulses and clears
        @(negedge clk); sel = 3'd0;
        for (int i = 0; i < 60; i++) begin
            rise = 1'($urandom); fall = 1'($urandom); clr = ($urandom % 8) == 0;
            step(); #2;
        end
        clr = 0; rise = 0; fall = 0;

        // R3: direct
        sel = 3'd1;
        for (int i = 0; i < 30; i++) begin
            clr = ($urandom % 6) == 0; step(); #2;
        end
        clr = 0;

        // R4 / R7: spacing of each tap after a clear
        for (int s = 2; s <= 5; s++) begin
            sel = 3'(s); clr = 1'b1;
            step(); #2; clr = 1'b0;
            check(en === 1'b0, "R7", int'(en), 0);
            cnt_hi = 0;
            for (int i = 0; i < 3 * divisor(3'(s)); i++) begin
                step(); if (en) cnt_hi++;
            end
            #2;
            check(cnt_hi == 3, "R4", cnt_hi, 3);
        end

        // R5: first-count latency across random phases, no clear between
        for (int trial = 0; trial < 24; trial++) begin
            logic [2:0] ns;
            sel = 3'd0;
            run(1 + ($urandom % 1500)); #2;
            ns = 3'(2 + ($urandom % 4));
            ph = model_cnt;
            exp_lat = ((divisor(ns) - 1 - (ph % divisor(ns))) % divisor(ns)) + 1;
            sel = ns;
            lat = 0;
            for (int i = 0; i < 1100 && lat == 0; i++) begin
                step(); if (en) lat = i + 1;
            end
            #2;
            check(lat == exp_lat && lat >= 1 && lat <= divisor(ns), "R5", lat, exp_lat);
        end

        // R5: hop between taps without clearing
        for (int i = 0; i < 400; i++) begin
            if ((i % 37) == 0) sel = 3'(2 + ($urandom % 4));
            step(); #2;
        end

        // R6: external edges, the unchosen input ignored
        for (int s = 6; s <= 7; s++) begin
            sel = 3'(s);
            for (int i = 0; i < 80; i++) begin
                rise = 1'($urandom); fall = 1'($urandom); clr = ($urandom % 5) == 0;
                step(); #2;
            end
        end
        rise = 0; fall = 0; clr = 0;

        // R7: clear mid-run realigns the tap
        sel = 3'd3;
        run(45); #2;
        clr = 1'b1; step(); #2; clr = 1'b0;
        lat = 0;
        for (int i = 0; i < 100 && lat == 0; i++) begin
            step(); if (en) lat = i + 1;
        end
        #2;
        check(lat == 64, "R7", lat, 64);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule